// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Engine

This block is a synthesizable behavioural model of the control side of a byte-wide NOR flash device. It has a small storage array split into erase blocks of equal size. The host bus is a synchronous abstraction. On a clock edge where chip enable and write enable are low and output enable is high, the block takes a write cycle. While chip enable and output enable are low and write enable is high, it presents read data. Write cycles carry 8-bit commands. A few of them change which source a read returns: the array, the status byte or the identification bytes. Others start two-cycle program and block-erase sequences. These run for a set number of clock cycles under an internal sequencer.

An erase in progress can be paused and later continued. While it is paused, the other blocks can be read. Error flags in the status byte stay set until the host clears them. An active-low ready/busy pin shows when an operation is running. A power-down pin returns the control logic to its start state and floats the read path. Two fault-injection inputs let a test force the program or erase error flag, since no real cell verification takes place.

Top module: `pflash_core`

## Requirements
- R1: After `rst_n` or while `pd_n` is low, the sequencer returns to idle, reads come from the array and the error flags are cleared. Array contents survive `pd_n`. While `pd_n` is low, `rdata_oe` is 0, `ry_by` is 1 and every bus write is ignored. An operation in progress is abandoned without touching the array.
- R2: In the idle state, FFh selects array reads, 90h selects identification reads and 70h selects status reads. Any code that is not a defined command leaves the read source unchanged.
- R3: The program command is 40h or 10h. The next write cycle carries the target address and data, and the stored byte becomes the old byte ANDed with that data.
- R4: The erase command is 20h, followed by D0h with any address in the target block. The block index is the top BLK_W address bits. Every byte of that block becomes FFh and the other blocks are unchanged.
- R5: If the write after 20h carries any value other than D0h, status bits 5 and 4 are set, reads switch to status and nothing is erased.
- R6: The status byte has bit 7 = ready, bit 6 = erase paused, bit 5 = erase error, bit 4 = program error and bit 3 = no VPP. Bits 2..0 are always 0.
- R7: Bits 5..3 are sticky. Only command 50h in the idle state, `pd_n` low or `rst_n` low clears them. Changing the read source does not clear them.
- R8: `vpp_ok` is sampled only on the cycle that carries the program data or the erase confirm. If it is low, bit 3 is set, no operation starts and `ry_by` stays high.
- R9: While an operation runs, a read returns the status byte with bit 7 = 0. After the operation ends, reads keep returning status until a command changes the source. Every write during programming is ignored.
- R10: `ry_by` is low for exactly PROG_CYC cycles after a program is accepted. For an erase it is low for ERASE_CYC cycles, not counting cycles spent paused. It is high at all other times.
- R11: During an erase, only B0h is accepted. B0h pauses the erase, setting bits 7 and 6 and raising `ry_by`. While paused, only FFh, 70h and D0h are accepted, and D0h continues the erase and clears bit 6.
- R12: In identification mode, address 0 reads MFR_ID (default 89h), address 1 reads DEV_ID (default A0h) and any other address reads 00h.
- R13: If `flt_prog` is high on the final cycle of a program, bit 4 is set, and the data is still written. If `flt_erase` is high on the final cycle of an erase, bit 5 is set, and the block is still erased.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also presets the array to FFh |
| pd_n | input | 1 | Active-low power-down / reset pin |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Command or program data |
| vpp_ok | input | 1 | Programming supply present |
| flt_prog | input | 1 | Forces a program error at completion |
| flt_erase | input | 1 | Forces an erase error at completion |
| rdata | output | 8 | Read data (00h when not driven) |
| rdata_oe | output | 1 | Read data valid / output driven |
| ry_by | output | 1 | Low while a program or erase runs |

## Verification
Some rules are checked by assertions on every cycle. The pins stay floated and ready during power-down. The reserved status bits stay zero. A paused erase always reads as ready. Error flags only drop after a clear command or power-down. Busy only starts after a bus write, and a read during busy returns a status byte with bit 7 low. Other behaviour can only be shown by the bench's scenarios. These are the AND semantics of programming across the whole array, the erase footprint of each block, exact busy lengths across a pause, identification values, sequence and supply errors, and commands being ignored in each state.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_PSET,
    FS_ESET,
    FS_PROG,
    FS_ERASE,
    FS_SUSP
  } fsm_e;

  typedef enum logic [1:0] {
    SRC_ARRAY,
    SRC_IDENT,
    SRC_STAT
  } rdsrc_e;

  typedef struct packed {
    logic ers_err;
    logic prg_err;
    logic no_vpp;
  } errs_t;

  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_RD_STAT   = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
  localparam logic [7:0] CMD_ERS_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERS_GO    = 8'hD0;
  localparam logic [7:0] CMD_PRG_A     = 8'h40;
  localparam logic [7:0] CMD_PRG_B     = 8'h10;
  localparam logic [7:0] CMD_SUSPEND   = 8'hB0;

endpackage

// File: rtl/pflash_seq.sv
module pflash_seq
  import pflash_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BLK_W     = 2,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              wr_cyc,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              vpp_ok,
  input  logic              flt_prog,
  input  logic              flt_erase,
  output logic              prg_we,
  output logic [ADDR_W-1:0] prg_addr,
  output logic [7:0]        prg_data,
  output logic              ers_we,
  output logic [BLK_W-1:0]  ers_blk,
  output rdsrc_e            src,
  output logic [7:0]        status,
  output logic              busy
);

  localparam int CNT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  fsm_e              state_q, state_d;
  rdsrc_e            src_q, src_d;
  errs_t             err_q, err_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [BLK_W-1:0]  blk_q;
  logic              tgt_en;
  logic              blk_en;
  logic              prg_fire;
  logic              ers_fire;
  logic              wr_ok;

  assign wr_ok = wr_cyc & pd_n;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    src_d    = src_q;
    err_d    = err_q;
    cnt_d    = cnt_q;
    tgt_en   = 1'b0;
    blk_en   = 1'b0;
    prg_fire = 1'b0;
    ers_fire = 1'b0;
    unique case (state_q)
      FS_IDLE: begin
        if (wr_ok) begin
          unique case (wr_data)
            CMD_RD_ARRAY:  src_d = SRC_ARRAY;
            CMD_RD_IDENT:  src_d = SRC_IDENT;
            CMD_RD_STAT:   src_d = SRC_STAT;
            CMD_CLR_STAT:  err_d = '0;
            CMD_ERS_SETUP: begin
              state_d = FS_ESET;
              src_d   = SRC_STAT;
            end
            CMD_PRG_A, CMD_PRG_B: begin
              state_d = FS_PSET;
              src_d   = SRC_STAT;
            end
            default: ;
          endcase
        end
      end
      FS_PSET: begin
        if (wr_ok) begin
          src_d = SRC_STAT;
          if (!vpp_ok) begin
            err_d.no_vpp = 1'b1;
            state_d      = FS_IDLE;
          end else begin
            state_d = FS_PROG;
            cnt_d   = CNT_W'(PROG_CYC - 1);
            tgt_en  = 1'b1;
          end
        end
      end
      FS_ESET: begin
        if (wr_ok) begin
          src_d = SRC_STAT;
          if (wr_data != CMD_ERS_GO) begin
            err_d.ers_err = 1'b1;
            err_d.prg_err = 1'b1;
            state_d       = FS_IDLE;
          end else if (!vpp_ok) begin
            err_d.no_vpp = 1'b1;
            state_d      = FS_IDLE;
          end else begin
            state_d = FS_ERASE;
            cnt_d   = CNT_W'(ERASE_CYC - 1);
            blk_en  = 1'b1;
          end
        end
      end
      FS_PROG: begin
        if (cnt_q == '0) begin
          prg_fire = 1'b1;
          state_d  = FS_IDLE;
          if (flt_prog) err_d.prg_err = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      FS_ERASE: begin
        if (cnt_q == '0) begin
          ers_fire = 1'b1;
          state_d  = FS_IDLE;
          if (flt_erase) err_d.ers_err = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
          if (wr_ok && wr_data == CMD_SUSPEND) state_d = FS_SUSP;
        end
      end
      FS_SUSP: begin
        if (wr_ok) begin
          unique case (wr_data)
            CMD_RD_ARRAY: src_d = SRC_ARRAY;
            CMD_RD_STAT:  src_d = SRC_STAT;
            CMD_ERS_GO: begin
              state_d = FS_ERASE;
              src_d   = SRC_STAT;
            end
            default: ;
          endcase
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      src_q   <= SRC_ARRAY;
      err_q   <= '0;
      cnt_q   <= '0;
    end else if (!pd_n) begin
      state_q <= FS_IDLE;
      src_q   <= SRC_ARRAY;
      err_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      err_q   <= err_d;
      cnt_q   <= cnt_d;
    end
  end

  // Operand latches with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (tgt_en) begin
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else if (blk_en) begin
      blk_q <= wr_addr[ADDR_W-1 -: BLK_W];
    end
  end

  assign busy     = (state_q == FS_PROG) || (state_q == FS_ERASE);
  assign prg_we   = prg_fire & pd_n;
  assign ers_we   = ers_fire & pd_n;
  assign prg_addr = addr_q;
  assign prg_data = data_q;
  assign ers_blk  = blk_q;
  assign src      = src_q;
  assign status   = {~busy, (state_q == FS_SUSP), err_q.ers_err,
                     err_q.prg_err, err_q.no_vpp, 3'b000};

endmodule

// File: rtl/pflash_store.sv
module pflash_store #(
  parameter int ADDR_W = 6,
  parameter int BLK_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prg_we,
  input  logic [ADDR_W-1:0] prg_addr,
  input  logic [7:0]        prg_data,
  input  logic              ers_we,
  input  logic [BLK_W-1:0]  ers_blk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int NBLK  = 1 << BLK_W;
  localparam int OFF_W = ADDR_W - BLK_W;
  localparam int BSZ   = 1 << OFF_W;

  logic [NBLK-1:0][7:0] blk_rd;
  logic [BLK_W-1:0]     prg_blk;
  logic [OFF_W-1:0]     prg_off;
  logic [OFF_W-1:0]     rd_off;

  assign prg_blk = prg_addr[ADDR_W-1 -: BLK_W];
  assign prg_off = prg_addr[OFF_W-1:0];
  assign rd_off  = rd_addr[OFF_W-1:0];

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic [7:0] mem [BSZ];
    logic       ers_hit;
    logic       prg_hit;

    assign ers_hit = ers_we && (ers_blk == BLK_W'(b));
    assign prg_hit = prg_we && (prg_blk == BLK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < BSZ; i++) mem[i] <= 8'hFF;
      end else if (ers_hit) begin
        for (int i = 0; i < BSZ; i++) mem[i] <= 8'hFF;
      end else if (prg_hit) begin
        mem[prg_off] <= mem[prg_off] & prg_data;
      end
    end

    assign blk_rd[b] = mem[rd_off];
  end

  assign rd_data = blk_rd[rd_addr[ADDR_W-1 -: BLK_W]];

endmodule

// File: rtl/pflash_rdmux.sv
module pflash_rdmux
  import pflash_pkg::*;
#(
  parameter int         ADDR_W = 6,
  parameter logic [7:0] MFR_ID = 8'h89,
  parameter logic [7:0] DEV_ID = 8'hA0
) (
  input  logic              pd_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  rdsrc_e            src,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        arr_data,
  input  logic [7:0]        status,
  output logic [7:0]        rd_data,
  output logic              rd_oe
);

  logic [7:0] ident;
  logic [7:0] pick;

  assign rd_oe = pd_n & ~ce_n & ~oe_n & we_n;

  always_comb begin
    if (addr == ADDR_W'(0))      ident = MFR_ID;
    else if (addr == ADDR_W'(1)) ident = DEV_ID;
    else                         ident = 8'h00;
  end

  always_comb begin
    unique case (src)
      SRC_ARRAY: pick = arr_data;
      SRC_IDENT: pick = ident;
      SRC_STAT:  pick = status;
      default:   pick = status;
    endcase
  end

  assign rd_data = rd_oe ? pick : 8'h00;

endmodule

// File: rtl/pflash_core.sv
module pflash_core
  import pflash_pkg::*;
#(
  parameter int         ADDR_W    = 6,
  parameter int         BLK_W     = 2,
  parameter int         PROG_CYC  = 4,
  parameter int         ERASE_CYC = 8,
  parameter logic [7:0] MFR_ID    = 8'h89,
  parameter logic [7:0] DEV_ID    = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              vpp_ok,
  input  logic              flt_prog,
  input  logic              flt_erase,
  output logic [7:0]        rdata,
  output logic              rdata_oe,
  output logic              ry_by
);

  logic              wr_cyc;
  logic              prg_we;
  logic [ADDR_W-1:0] prg_addr;
  logic [7:0]        prg_data;
  logic              ers_we;
  logic [BLK_W-1:0]  ers_blk;
  rdsrc_e            src;
  logic [7:0]        sr_byte;
  logic              busy;
  logic [7:0]        arr_data;

  assign wr_cyc = ~ce_n & ~we_n & oe_n;

  pflash_seq #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n),
    .wr_cyc(wr_cyc), .wr_addr(addr), .wr_data(wdata),
    .vpp_ok(vpp_ok), .flt_prog(flt_prog), .flt_erase(flt_erase),
    .prg_we(prg_we), .prg_addr(prg_addr), .prg_data(prg_data),
    .ers_we(ers_we), .ers_blk(ers_blk),
    .src(src), .status(sr_byte), .busy(busy)
  );

  pflash_store #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .prg_we(prg_we), .prg_addr(prg_addr), .prg_data(prg_data),
    .ers_we(ers_we), .ers_blk(ers_blk),
    .rd_addr(addr), .rd_data(arr_data)
  );

  pflash_rdmux #(
    .ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_rdmux (
    .pd_n(pd_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .src(src), .addr(addr), .arr_data(arr_data), .status(sr_byte),
    .rd_data(rdata), .rd_oe(rdata_oe)
  );

  assign ry_by = ~(busy & pd_n);

endmodule

// File: rtl/pflash_core_chk.sv
module pflash_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pd_n,
  input logic       ce_n,
  input logic       we_n,
  input logic       oe_n,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       rdata_oe,
  input logic       ry_by,
  input logic [7:0] sr
);

  logic wr;
  assign wr = ~ce_n & ~we_n & oe_n;

  // R1: power-down floats the read path and reports ready
  assert_pd_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> (!rdata_oe && ry_by));

  // R6: reserved status bits never set
  assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sr[2:0] == 3'b000);

  // R11: a paused erase is always ready
  assert_susp_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sr[6] |-> (sr[7] && ry_by));

  // R7: error flags only fall after a clear command or power-down
  assert_sticky_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pd_n) && !($past(wr) && $past(wdata) == 8'h50))
      |-> (($past(sr[5:3]) & ~sr[5:3]) == 3'b000));

  // R9: a read while busy returns a busy status byte
  assert_busy_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ry_by && rdata_oe) |-> ((rdata & 8'h87) == 8'h00));

  // R10: busy only begins right after an accepted bus write
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ry_by) |-> $past(wr));

endmodule

bind pflash_core pflash_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n),
  .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
  .ry_by(ry_by), .sr(sr_byte)
);

// File: tb/pflash_core_tb.sv
module pflash_core_tb;

  localparam int AW    = 6;
  localparam int BW    = 2;
  localparam int PC    = 4;
  localparam int EC    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int BSZ   = 1 << (AW - BW);

  logic          clk = 1'b0;
  logic          rst_n, pd_n, ce_n, we_n, oe_n, vpp_ok, flt_prog, flt_erase;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic          rdata_oe, ry_by;

  logic [7:0] model [DEPTH];
  int         n_chk = 0;
  int         n_err = 0;
  logic       last_oe;

  always #2.5 clk = ~clk;

  pflash_core #(.ADDR_W(AW), .BLK_W(BW), .PROG_CYC(PC), .ERASE_CYC(EC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .vpp_ok(vpp_ok),
    .flt_prog(flt_prog), .flt_erase(flt_erase),
    .rdata(rdata), .rdata_oe(rdata_oe), .ry_by(ry_by)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #1;
    d = rdata; last_oe = rdata_oe;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (ry_by === 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic sweep_array(input string tag);
    logic [7:0] d;
    wr('0, 8'hFF);
    for (int a = 0; a < DEPTH; a++) begin
      rd(AW'(a), d);
      check(tag, d, model[a]);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, n1, n2;
    rst_n = 1'b0; pd_n = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; wdata = '0; vpp_ok = 1'b1; flt_prog = 1'b0; flt_erase = 1'b0;
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state: array source, cleared status
    rd(5, d); check("R1 reset array read", d, 8'hFF);
    check("R1 read enable", last_oe, 1);
    wr(0, 8'h70); rd(0, d); check("R1 R6 reset status", d, 8'h80);

    // R12 identification, R2 invalid code ignored
    wr(0, 8'h90);
    rd(0, d); check("R12 mfr id", d, 8'h89);
    rd(1, d); check("R12 dev id", d, 8'hA0);
    rd(2, d); check("R12 other addr", d, 8'h00);
    wr(0, 8'h33); rd(0, d); check("R2 invalid keeps ident", d, 8'h89);
    wr(0, 8'hFF); rd(7, d); check("R2 array select", d, 8'hFF);
    wr(0, 8'h5A); rd(7, d); check("R2 invalid keeps array", d, 8'hFF);

    // R3 R10 program sweep, two passes
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < DEPTH; a++) begin
        logic [7:0] pat;
        pat = (p == 0) ? 8'((a * 37 + 5) & 255) : 8'((a * 11 + 195) & 255);
        wr(0, a[0] ? 8'h10 : 8'h40);
        wr(AW'(a), pat);
        wait_rdy(n);
        model[a] = model[a] & pat;
        check("R10 program busy length", n, PC);
        rd(0, d); check("R9 status after program", d, 8'h80);
      end
      sweep_array("R3 program AND result");
    end

    // R9 commands ignored while programming
    wr(0, 8'h40); wr(9, 8'h0F);
    rd(0, d); check("R9 busy status read", d, 8'h00);
    wr(0, 8'h20); wr(0, 8'hFF);
    wait_rdy(n);
    rd(0, d); check("R9 status kept after done", d, 8'h80);
    wr(0, 8'h77); rd(0, d); check("R9 setup during program ignored", d, 8'h80);
    model[9] = model[9] & 8'h0F;
    wr(0, 8'hFF); rd(9, d); check("R3 R9 byte programmed", d, model[9]);

    // R4 erase block 1
    wr(0, 8'h20); wr(AW'(BSZ + 3), 8'hD0);
    wait_rdy(n); check("R10 erase busy length", n, EC);
    rd(0, d); check("R4 status after erase", d, 8'h80);
    for (int i = 0; i < BSZ; i++) model[BSZ + i] = 8'hFF;
    sweep_array("R4 erase footprint");

    // R5 sequence error, R7 sticky and clear
    wr(0, 8'h20); wr(AW'(2 * BSZ), 8'h77);
    rd(0, d); check("R5 sequence error status", d, 8'hB0);
    wr(0, 8'hFF); rd(AW'(2 * BSZ), d); check("R5 no erase on error", d, model[2 * BSZ]);
    wr(0, 8'h70); rd(0, d); check("R7 flags survive source change", d, 8'hB0);
    wr(0, 8'h50); rd(0, d); check("R7 clear command", d, 8'h80);

    // R8 VPP missing
    vpp_ok = 1'b0;
    wr(0, 8'h40); wr(3, 8'h00);
    check("R8 no busy without vpp (program)", ry_by, 1);
    rd(0, d); check("R8 vpp flag on program", d, 8'h88);
    wr(0, 8'h50);
    wr(0, 8'h20); wr(0, 8'hD0);
    check("R8 no busy without vpp (erase)", ry_by, 1);
    rd(0, d); check("R8 vpp flag on erase", d, 8'h88);
    vpp_ok = 1'b1;
    wr(0, 8'hFF);
    rd(3, d); check("R8 program not done", d, model[3]);
    rd(0, d); check("R8 erase not done", d, model[0]);
    wr(0, 8'h50);

    // R11 suspend and resume of block 2
    wr(0, 8'h20); wr(AW'(2 * BSZ + 1), 8'hD0);
    n1 = 0;
    while (n1 < 3 && ry_by === 1'b0) begin n1++; @(negedge clk); end
    wr(0, 8'hB0);                     // this cycle also elapses busy
    rd(0, d); check("R11 suspended status", d, 8'hC0);
    check("R11 ready while suspended", ry_by, 1);
    wr(0, 8'h90); rd(0, d); check("R11 ident refused when suspended", d, 8'hC0);
    wr(0, 8'hFF); rd(AW'(3 * BSZ + 2), d); check("R11 array read when suspended", d, model[3 * BSZ + 2]);
    wr(0, 8'hD0);
    wait_rdy(n2);
    check("R10 R11 busy total across suspend", n1 + 1 + n2, EC);
    rd(0, d); check("R11 resumed to completion", d, 8'h80);
    for (int i = 0; i < BSZ; i++) model[2 * BSZ + i] = 8'hFF;
    sweep_array("R11 erased after resume");

    // R11 only suspend accepted during erase
    wr(0, 8'h20); wr(AW'(3 * BSZ), 8'hD0);
    wr(0, 8'hFF);
    rd(0, d); check("R11 array cmd refused while erasing", d, 8'h00);
    wait_rdy(n);
    rd(0, d); check("R11 status after erase", d, 8'h80);
    for (int i = 0; i < BSZ; i++) model[3 * BSZ + i] = 8'hFF;

    // R13 fault injection
    flt_prog = 1'b1;
    wr(0, 8'h40); wr(2, 8'h55); wait_rdy(n);
    flt_prog = 1'b0;
    model[2] = model[2] & 8'h55;
    rd(0, d); check("R13 forced program error", d, 8'h90);
    wr(0, 8'hFF); rd(2, d); check("R13 data still written", d, model[2]);
    wr(0, 8'h50);
    flt_erase = 1'b1;
    wr(0, 8'h20); wr(4, 8'hD0); wait_rdy(n);
    flt_erase = 1'b0;
    rd(0, d); check("R13 forced erase error", d, 8'hA0);
    wr(0, 8'h50); rd(0, d); check("R13 R7 cleared", d, 8'h80);
    for (int i = 0; i < BSZ; i++) model[i] = 8'hFF;
    sweep_array("R13 block still erased");

    // R1 power-down
    wr(0, 8'h20); wr(0, 8'h77); wr(0, 8'h90);
    pd_n = 1'b0;
    @(negedge clk);
    rd(0, d);
    check("R1 outputs floated in power-down", last_oe, 0);
    check("R1 ready in power-down", ry_by, 1);
    wr(0, 8'h40);
    pd_n = 1'b1;
    @(negedge clk);
    rd(AW'(BSZ + 1), d); check("R1 array source after power-down", d, model[BSZ + 1]);
    wr(0, 8'h70); rd(0, d); check("R1 status cleared, writes ignored", d, 8'h80);

    // R1 power-down aborts a program
    model[5] = model[5];
    wr(0, 8'h40); wr(5, 8'h00);
    pd_n = 1'b0;
    #1 check("R1 ready as soon as power-down", ry_by, 1);
    @(negedge clk);
    pd_n = 1'b1;
    @(negedge clk);
    rd(5, d); check("R1 aborted program leaves array", d, model[5]);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule